// File: doc/BRIEF.md
# Transmit Pause Timer and Channel Gating

This block converts received flow-control pause requests into transmit suspension. A one-cycle request pulse carries a 16-bit pause length in quanta; a slot tick, one pulse per 512 bit times, counts that length down. While the count is non-zero a status bit reads 1. A fresh request always overwrites the remaining count, and a length of zero ends any pause at once.

The suspension is applied at one of two places, chosen by a configuration bit. In MAC mode a single MAC-level hold follows the timer. In channel mode the MAC-level hold stays off and each of the two DMA channels is held only when its own enable is set, so any subset of the channels can be paused. Each channel also has a software pause bit that holds it whatever the timer says. No hold ever changes while its frame is in flight: the MAC hold only updates while the MAC is idle between frames, and a channel hold only updates while that channel is between packets. A change requested mid-packet takes effect at the boundary.

Top module: `pause_gate`

## Requirements
- R1: `mac_tx_hold` keeps its value on every clock edge at which `mac_busy` is 1; a pending change is applied at the first edge with `mac_busy` 0.
- R2: A `pause_req` with non-zero `pause_quanta` N sets `pause_active` to 1 at that edge; `pause_active` returns to 0 at the edge of the Nth following `slot_tick`.
- R3: A `pause_req` reloads the count with its own `pause_quanta`, discarding the remaining count, and takes priority over a `slot_tick` in the same cycle.
- R4: A `pause_req` with `pause_quanta` 0 clears `pause_active` at that edge.
- R5: `pause_active` depends only on the timer; the software pause bits and the mode bit have no effect on it.
- R6: With `cfg_chan_mode` 0, `mac_tx_hold` follows `pause_active` (subject to R1) and the per-channel enables do not hold any channel.
- R7: With `cfg_chan_mode` 1, `mac_tx_hold` is 0 and `dma_hold[i]` follows `pause_active` for each channel i whose `cfg_ch_fc_en[i]` is 1 (bit 0 is channel 0, bit 1 is channel 1).
- R8: `cfg_ch_sw_pause[i]` set to 1 holds channel i in either mode, with or without an active pause.
- R9: `dma_hold[i]` keeps its value on every clock edge at which `ch_busy[i]` is 1; a pending change is applied at the first edge with `ch_busy[i]` 0.
- R10: Reset (asynchronous, active low) clears the timer and all holds, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pause_req | input | 1 | One-cycle pulse: a valid pause request arrived |
| pause_quanta | input | 16 | Pause length in quanta, sampled with `pause_req` |
| slot_tick | input | 1 | One pulse per pause quantum (512 bit times) |
| mac_busy | input | 1 | MAC is in the middle of sending a frame |
| ch_busy | input | 2 | Per channel: channel is in the middle of a packet |
| cfg_chan_mode | input | 1 | 0 = hold at MAC level, 1 = hold per DMA channel |
| cfg_ch_fc_en | input | 2 | Per channel: obey the pause timer in channel mode |
| cfg_ch_sw_pause | input | 2 | Per channel: software-forced hold |
| mac_tx_hold | output | 1 | MAC-level transmit hold |
| dma_hold | output | 2 | Per-channel DMA transmit hold |
| pause_active | output | 1 | Pause interval still running |

## Verification
The gating is driven with every combination of the two channel enables under channel mode, so a swapped channel index or a missing enable gives a wrong hold pattern, and with the same enables under MAC mode to show that they are then ignored. Timer patterns cover a plain countdown to zero, a reload in the middle of a countdown with a tick in the same cycle, and a zero-length request, which separate reload priority and off-by-one errors in the countdown. Busy patterns raise and drop holds while the MAC or a single channel is mid-packet, which shows whether a hold waits for the boundary and whether one channel's busy signal leaks into the other's hold. Software pause bits are set with the timer idle and the status bit checked, which separates the forced hold from the timer state.

// File: rtl/pause_gate_pkg.sv
package pause_gate_pkg;

    // Where a running pause is applied.
    typedef enum logic {
        SITE_MAC     = 1'b0,
        SITE_CHANNEL = 1'b1
    } hold_site_e;

    // Hold request for one DMA channel, from the timer, the mode and the channel's own bits.
    function automatic logic chan_want(input hold_site_e site,
                                       input logic       fc_en,
                                       input logic       sw_pause,
                                       input logic       active);
        return sw_pause | ((site == SITE_CHANNEL) & fc_en & active);
    endfunction

endpackage

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [QW-1:0] quanta,
    input  logic          tick,
    output logic          active_next,
    output logic          active
);

    typedef struct packed {
        logic [QW-1:0] count;
        logic          active;
    } timer_t;

    localparam logic [QW-1:0] ZERO = '0;
    localparam logic [QW-1:0] ONE  = {{(QW-1){1'b0}}, 1'b1};

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.count = quanta;
        end else if (tick && (st_q.count != ZERO)) begin
            st_d.count = st_q.count - ONE;
        end
        st_d.active = (st_d.count != ZERO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_next = st_d.active;
    assign active      = st_q.active;

endmodule

// File: rtl/tx_boundary_hold.sv
module tx_boundary_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic busy,
    output logic hold
);

    typedef struct packed {
        logic hold;
    } bhold_t;

    bhold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!busy) begin
            st_d.hold = want;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold = st_q.hold;

endmodule

// File: rtl/pause_gate.sv
module pause_gate #(
    parameter int QW  = 16,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pause_req,
    input  logic [QW-1:0]  pause_quanta,
    input  logic           slot_tick,
    input  logic           mac_busy,
    input  logic [NCH-1:0] ch_busy,
    input  logic           cfg_chan_mode,
    input  logic [NCH-1:0] cfg_ch_fc_en,
    input  logic [NCH-1:0] cfg_ch_sw_pause,
    output logic           mac_tx_hold,
    output logic [NCH-1:0] dma_hold,
    output logic           pause_active
);
    import pause_gate_pkg::*;

    hold_site_e site;
    logic       active_next;
    logic       mac_want;

    assign site = hold_site_e'(cfg_chan_mode);

    pause_quanta_timer #(.QW(QW)) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (pause_req),
        .quanta      (pause_quanta),
        .tick        (slot_tick),
        .active_next (active_next),
        .active      (pause_active)
    );

    assign mac_want = (site == SITE_MAC) & active_next;

    tx_boundary_hold mac_hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (mac_want),
        .busy  (mac_busy),
        .hold  (mac_tx_hold)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic want;
        assign want = chan_want(site, cfg_ch_fc_en[i], cfg_ch_sw_pause[i], active_next);

        tx_boundary_hold ch_hold_i (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (want),
            .busy  (ch_busy[i]),
            .hold  (dma_hold[i])
        );
    end

endmodule

// File: rtl/pause_gate_chk.sv
module pause_gate_chk #(
    parameter int QW  = 16,
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pause_req,
    input logic [QW-1:0]  pause_quanta,
    input logic           slot_tick,
    input logic           mac_busy,
    input logic [NCH-1:0] ch_busy,
    input logic           cfg_chan_mode,
    input logic [NCH-1:0] cfg_ch_fc_en,
    input logic [NCH-1:0] cfg_ch_sw_pause,
    input logic           mac_tx_hold,
    input logic [NCH-1:0] dma_hold,
    input logic           pause_active
);

    assert_mac_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mac_busy |=> $stable(mac_tx_hold));

    assert_load_sets_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && (pause_quanta != '0)) |=> pause_active);

    assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && (pause_quanta == '0)) |=> !pause_active);

    assert_status_timer_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pause_req && !slot_tick) |=> $stable(pause_active));

    assert_mac_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chan_mode && !mac_busy) |=> (mac_tx_hold == pause_active));

    assert_mac_off_chmode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chan_mode && !mac_busy) |=> !mac_tx_hold);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_ch_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_chan_mode && cfg_ch_fc_en[i] && !cfg_ch_sw_pause[i] && !ch_busy[i])
            |=> (dma_hold[i] == pause_active));

        assert_sw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_ch_sw_pause[i] && !ch_busy[i]) |=> dma_hold[i]);

        assert_ch_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ch_busy[i] |=> $stable(dma_hold[i]));
    end

endmodule

bind pause_gate pause_gate_chk #(.QW(QW), .NCH(NCH)) chk_i (.*);

// File: tb/pause_gate_tb_top.sv
`timescale 1ns/1ps
module pause_gate_tb_top;

    localparam int QW  = 16;
    localparam int NCH = 2;
    localparam int NROW = 26;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pause_req = 1'b0;
    logic [QW-1:0]  pause_quanta = '0;
    logic           slot_tick = 1'b0;
    logic           mac_busy = 1'b0;
    logic [NCH-1:0] ch_busy = '0;
    logic           cfg_chan_mode = 1'b0;
    logic [NCH-1:0] cfg_ch_fc_en = '0;
    logic [NCH-1:0] cfg_ch_sw_pause = '0;
    logic           mac_tx_hold;
    logic [NCH-1:0] dma_hold;
    logic           pause_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pause_gate #(.QW(QW), .NCH(NCH)) dut_i (.*);

    typedef struct packed {
        logic          req;
        logic [15:0]   q;
        logic          tick;
        logic          mb;
        logic [1:0]    cb;
        logic          mode;
        logic [1:0]    fc;
        logic [1:0]    sw;
        logic          e_act;
        logic          e_mac;
        logic [1:0]    e_dma;
    } vec_t;

    // Outputs are the values expected after the clock edge at which the row is applied.
    localparam vec_t TBL [0:NROW-1] = '{
        '{1'b1, 16'd3, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00}, // 0  R2 load 3
        '{1'b0, 16'd0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00}, // 1  R2 ->2
        '{1'b0, 16'd0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00}, // 2  R2 ->1
        '{1'b0, 16'd0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}, // 3  R2 ->0
        '{1'b1, 16'd2, 1'b0, 1'b1, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 2'b00}, // 4  R1 busy
        '{1'b0, 16'd0, 1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 2'b00}, // 5  R1 busy
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00}, // 6  R1 boundary
        '{1'b1, 16'd5, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00}, // 7  R3 reload+tick
        '{1'b0, 16'd0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00}, // 8  R3 ->4
        '{1'b1, 16'd0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}, // 9  R4 zero
        '{1'b1, 16'd2, 1'b0, 1'b0, 2'b00, 1'b1, 2'b01, 2'b00, 1'b1, 1'b0, 2'b01}, // 10 R7 ch0
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b10, 2'b00, 1'b1, 1'b0, 2'b10}, // 11 R7 ch1
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b11, 2'b00, 1'b1, 1'b0, 2'b11}, // 12 R7 both
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 2'b00, 1'b1, 1'b0, 2'b00}, // 13 R7 none
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b01, 1'b1, 2'b11, 2'b00, 1'b1, 1'b0, 2'b10}, // 14 R9 ch0 busy
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b11, 2'b00, 1'b1, 1'b0, 2'b11}, // 15 R9 boundary
        '{1'b0, 16'd0, 1'b1, 1'b0, 2'b00, 1'b1, 2'b11, 2'b00, 1'b1, 1'b0, 2'b11}, // 16 R7 ->1
        '{1'b0, 16'd0, 1'b1, 1'b0, 2'b00, 1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 2'b00}, // 17 R7 ->0
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 2'b01}, // 18 R8 sw mac mode
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 2'b11, 1'b0, 1'b0, 2'b11}, // 19 R8 sw ch mode
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}, // 20 R8 release
        '{1'b1, 16'd1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b11, 2'b00, 1'b1, 1'b1, 2'b00}, // 21 R6 enables ignored
        '{1'b0, 16'd0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 2'b00}, // 22 R6 expire
        '{1'b1, 16'd4, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00}, // 23 R6 mac hold
        '{1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 2'b00, 1'b1, 1'b0, 2'b00}, // 24 R7 mac off
        '{1'b1, 16'd0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}  // 25 R4 zero
    };

    function automatic string row_tag(input int r);
        if (r <= 3)  return "R2";
        if (r <= 6)  return "R1";
        if (r <= 8)  return "R3";
        if (r == 9)  return "R4";
        if (r == 14 || r == 15) return "R9";
        if (r <= 17) return "R7";
        if (r <= 20) return "R8/R5";
        if (r <= 23) return "R6";
        if (r == 24) return "R7";
        return "R4";
    endfunction

    task automatic chk(input string what, input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic req, input logic [15:0] q, input logic tick,
                         input logic mb, input logic [1:0] cb, input logic mode,
                         input logic [1:0] fc, input logic [1:0] sw);
        pause_req       = req;
        pause_quanta    = q;
        slot_tick       = tick;
        mac_busy        = mb;
        ch_busy         = cb;
        cfg_chan_mode   = mode;
        cfg_ch_fc_en    = fc;
        cfg_ch_sw_pause = sw;
        @(posedge clk);
        #1;
        pause_req = 1'b0;
        slot_tick = 1'b0;
    endtask

    task automatic chk_all(input string req, input int a, input int m, input int d);
        chk("pause_active", req, int'(pause_active), a);
        chk("mac_tx_hold",  req, int'(mac_tx_hold),  m);
        chk("dma_hold",     req, int'(dma_hold),     d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk_all("R10", int'(pause_active), 0, 0); // R10 outputs in reset
        chk("pause_active", "R10", int'(pause_active), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_all("R10", 0, 0, 0);

        for (int r = 0; r < NROW; r++) begin
            drive(TBL[r].req, TBL[r].q, TBL[r].tick, TBL[r].mb, TBL[r].cb,
                  TBL[r].mode, TBL[r].fc, TBL[r].sw);
            chk_all(row_tag(r), int'(TBL[r].e_act), int'(TBL[r].e_mac), int'(TBL[r].e_dma));
        end

        // R1: release of the MAC hold waits for the end of the frame
        drive(1'b1, 16'd1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00);
        chk_all("R1", 1, 1, 0);
        drive(1'b0, 16'd0, 1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 2'b00);
        chk_all("R1", 0, 1, 0);
        drive(1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00);
        chk_all("R1", 0, 0, 0);

        // R9: software hold on channel 1 raised and dropped mid-packet
        drive(1'b0, 16'd0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, 2'b10);
        chk_all("R9", 0, 0, 0);
        drive(1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b10);
        chk_all("R9", 0, 0, 2);
        drive(1'b0, 16'd0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, 2'b00);
        chk_all("R9", 0, 0, 2);
        drive(1'b0, 16'd0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00);
        chk_all("R9", 0, 0, 0);

        // R2: long pause, then the maximum count is accepted
        drive(1'b1, 16'hFFFF, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00);
        chk_all("R2", 1, 1, 0);
        drive(1'b0, 16'd0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 2'b00);
        chk_all("R2", 1, 1, 0);

        // R10: reset in the middle of a pause clears everything
        rst_n = 1'b0;
        #1;
        chk_all("R10", 0, 0, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_all("R10", 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule